// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Sequencer

This block produces the pin-level bus timing of a small 8-bit processor whose low address byte and data byte share one set of lines. The core hands it a request naming one of five machine-cycle kinds, a 16-bit address and, for writes, a byte to store. The sequencer then advances through numbered T-states, one per clock. It drives the address latch enable, the active-low read and write strobes, the I/O-versus-memory select, a two-bit cycle status, the upper address byte and the shared lines.

A ready input lets slow memory or peripherals stretch the strobe phase with wait states. When the cycle ends, the block returns the sampled byte together with a one-clock done pulse. An opcode fetch uses the read timing and then adds one decode/execute state before the block goes back to idle. Requests are taken only while the block is idle.

Top module: `mux_bus_sequencer`

## Requirements
- R1: After reset, and whenever idle, ale is 0, rdN and wrN are 1, status is 00, ioM is 0, adDrive and hiDrive are 0, and done is 0.
- R2: In T1, the first clock after a request is accepted, ale is 1, adDrive is 1, adOut equals the low address byte, addrHi equals the upper address byte with hiDrive 1, and both strobes are inactive. ale is 0 in every other state.
- R3: In a read cycle (kind 1 memory read or kind 3 I/O read), rdN is low in T2 and in every wait state, and adDrive is 0 while rdN is low. adIn is captured at the clock edge that ends the last strobe state. That byte appears on rdByte in T3 together with done = 1, and rdN is high in T3.
- R4: In a write cycle (kind 2 memory write or kind 4 I/O write), wrN is low in T2 and in every wait state, and adOut carries the write byte with adDrive 1 while wrN is low. In T3, wrN is high, adDrive is 0 and done is 1.
- R5: ioM is 1 for the whole of an I/O cycle (kinds 3 and 4) and 0 for the whole of a memory cycle (kinds 0, 1 and 2).
- R6: status is 11 for an opcode fetch, 10 for a memory or I/O read, 01 for a memory or I/O write and 00 when idle. It is held for every T-state of the cycle.
- R7: An opcode fetch (kind 0) runs T1, T2, T3 with read timing, then a fourth state T4. In T4 both strobes are inactive, adDrive is 0, hiDrive is 1 and done is 1 with the fetched byte on rdByte. done is 0 in the fetch's T3.
- R8: ready is sampled at the end of T2 and at the end of each wait state. While it is 0, another wait state follows with the active strobe held low, so each low sample adds exactly one clock.
- R9: done is a single-clock pulse. A request presented while a cycle is in progress is ignored, and the block returns to idle after the cycle.
- R10: A request with a kind code of 5, 6 or 7 is ignored, and the outputs stay at their idle values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; one T-state per period |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken only while idle |
| reqKind | input | 3 | 0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write |
| reqAddr | input | 16 | Cycle address |
| reqData | input | 8 | Byte to write |
| ready | input | 1 | High lets the strobe phase end; low inserts a wait state |
| adIn | input | 8 | Value on the shared lines seen by the block |
| adOut | output | 8 | Value the block puts on the shared lines |
| adDrive | output | 1 | Output enable for the shared lines (0 = high impedance) |
| addrHi | output | 8 | Upper address byte |
| hiDrive | output | 1 | Output enable for the upper address byte |
| ale | output | 1 | Address latch enable |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| ioM | output | 1 | 1 for I/O cycles, 0 for memory cycles |
| status | output | 2 | Cycle-kind status |
| rdByte | output | 8 | Byte captured during a read or fetch |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The bench runs each of the five cycle kinds with distinct address and data bytes, so that a swapped byte lane, a wrong status or ioM code, or a strobe on the wrong direction shows up as a mismatch. Reads are repeated with zero, one and several wait states. These runs separate a strobe that is held for the right number of clocks from one released early, and a capture taken at the final strobe edge from one taken at the first. During the wait states the bench changes the read value and presents a competing request, which exposes sampling at the wrong edge and acceptance of requests mid-cycle. Undefined kind codes and fetch-specific checks on the extra T4 state complete the set.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

  typedef enum logic [2:0] {
    KIND_FETCH = 3'd0,
    KIND_MRD   = 3'd1,
    KIND_MWR   = 3'd2,
    KIND_IORD  = 3'd3,
    KIND_IOWR  = 3'd4
  } cycleKind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_TW,
    ST_T3,
    ST_T4
  } tState_t;

  localparam logic [1:0] STAT_IDLE  = 2'b00;
  localparam logic [1:0] STAT_WRITE = 2'b01;
  localparam logic [1:0] STAT_READ  = 2'b10;
  localparam logic [1:0] STAT_FETCH = 2'b11;

  // Strobes from the control unit into the datapath.
  typedef struct packed {
    logic loadReq;
    logic capture;
    logic driveAddr;
    logic driveData;
  } dpCtrl_t;

endpackage

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mux_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqKind,
  input  logic       ready,
  output dpCtrl_t    dpCtrl,
  output logic       ale,
  output logic       rdN,
  output logic       wrN,
  output logic       ioM,
  output logic [1:0] status,
  output logic       hiDrive,
  output logic       done
);

  tState_t    state, stateNext;
  cycleKind_t kind;
  logic       kindOk;
  logic       isFetch, isRead, isWrite, isIo;
  logic       strobePhase;

  assign kindOk = (reqKind <= 3'd4);

  assign isFetch = (kind == KIND_FETCH);
  assign isRead  = (kind == KIND_FETCH) || (kind == KIND_MRD) || (kind == KIND_IORD);
  assign isWrite = (kind == KIND_MWR) || (kind == KIND_IOWR);
  assign isIo    = (kind == KIND_IORD) || (kind == KIND_IOWR);

  assign strobePhase = (state == ST_T2) || (state == ST_TW);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid && kindOk) stateNext = ST_T1;
      ST_T1:   stateNext = ST_T2;
      ST_T2,
      ST_TW:   stateNext = ready ? ST_T3 : ST_TW;
      ST_T3:   stateNext = isFetch ? ST_T4 : ST_IDLE;
      ST_T4:   stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kind  <= KIND_FETCH;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && reqValid && kindOk)
        kind <= cycleKind_t'(reqKind);
    end
  end

  always_comb begin
    dpCtrl.loadReq   = (state == ST_IDLE) && reqValid && kindOk;
    dpCtrl.capture   = strobePhase && ready && isRead;
    dpCtrl.driveAddr = (state == ST_T1);
    dpCtrl.driveData = strobePhase && isWrite;
  end

  logic busy;
  assign busy    = (state != ST_IDLE);
  assign ale     = (state == ST_T1);
  assign rdN     = !(strobePhase && isRead);
  assign wrN     = !(strobePhase && isWrite);
  assign ioM     = busy && isIo;
  assign hiDrive = busy;
  assign done    = (state == ST_T4) || (state == ST_T3 && !isFetch);

  always_comb begin
    if (!busy)        status = STAT_IDLE;
    else if (isFetch) status = STAT_FETCH;
    else if (isRead)  status = STAT_READ;
    else              status = STAT_WRITE;
  end

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  assert_ale_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (rdN && wrN));

  assert_wait_rd_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && !ready) |=> !rdN);

  assert_wait_wr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN && !ready) |=> !wrN);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_idle_status_R6: assert property (@(posedge clk) disable iff (!rstN)
    (status == STAT_IDLE) |-> (rdN && wrN && !ale && !ioM));

  assert_iom_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hiDrive && !ale) |-> ($stable(ioM) && $stable(status)));

endmodule

// File: rtl/mux_bus_dp.sv
module mux_bus_dp
  import mux_bus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtrl_t              dpCtrl,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqData,
  input  logic [DATA_W-1:0]    adIn,
  output logic [DATA_W-1:0]    adOut,
  output logic                 adDrive,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]    rdByte
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wrReg;
  logic [DATA_W-1:0] rdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      wrReg   <= '0;
      rdReg   <= '0;
    end else begin
      if (dpCtrl.loadReq) begin
        addrReg <= reqAddr;
        wrReg   <= reqData;
      end
      if (dpCtrl.capture)
        rdReg <= adIn;
    end
  end

  assign adOut   = dpCtrl.driveAddr ? addrReg[DATA_W-1:0] : wrReg;
  assign adDrive = dpCtrl.driveAddr || dpCtrl.driveData;
  assign addrHi  = addrReg[ADDR_W-1 -: HI_W];
  assign rdByte  = rdReg;

  assert_lane_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(dpCtrl.driveAddr && dpCtrl.driveData));

endmodule

// File: rtl/mux_bus_sequencer.sv
module mux_bus_sequencer
  import mux_bus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [2:0]               reqKind,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqData,
  input  logic                     ready,
  input  logic [DATA_W-1:0]        adIn,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adDrive,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic                     hiDrive,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN,
  output logic                     ioM,
  output logic [1:0]               status,
  output logic [DATA_W-1:0]        rdByte,
  output logic                     done
);

  dpCtrl_t dpCtrl;

  mux_bus_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .ready    (ready),
    .dpCtrl   (dpCtrl),
    .ale      (ale),
    .rdN      (rdN),
    .wrN      (wrN),
    .ioM      (ioM),
    .status   (status),
    .hiDrive  (hiDrive),
    .done     (done)
  );

  mux_bus_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtrl  (dpCtrl),
    .reqAddr (reqAddr),
    .reqData (reqData),
    .adIn    (adIn),
    .adOut   (adOut),
    .adDrive (adDrive),
    .addrHi  (addrHi),
    .rdByte  (rdByte)
  );

  assert_read_float_R3: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adDrive);

  assert_write_drive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> adDrive);

  assert_ale_drive_R2: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (adDrive && hiDrive));

endmodule

// File: tb/mux_bus_sequencer_tb.sv
`timescale 1ns/1ps
module mux_bus_sequencer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqKind = 3'd0;
  logic [15:0] reqAddr = 16'h0;
  logic [7:0]  reqData = 8'h0;
  logic        ready = 1'b1;
  logic [7:0]  adIn = 8'h0;
  logic [7:0]  adOut;
  logic        adDrive;
  logic [7:0]  addrHi;
  logic        hiDrive;
  logic        ale, rdN, wrN, ioM;
  logic [1:0]  status;
  logic [7:0]  rdByte;
  logic        done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mux_bus_sequencer u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqData(reqData), .ready(ready), .adIn(adIn),
    .adOut(adOut), .adDrive(adDrive), .addrHi(addrHi), .hiDrive(hiDrive),
    .ale(ale), .rdN(rdN), .wrN(wrN), .ioM(ioM), .status(status),
    .rdByte(rdByte), .done(done)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkIdle(string req);
    check(req, "ale", ale, 0);
    check(req, "rdN", rdN, 1);
    check(req, "wrN", wrN, 1);
    check(req, "status", status, 0);
    check(req, "ioM", ioM, 0);
    check(req, "adDrive", adDrive, 0);
    check(req, "hiDrive", hiDrive, 0);
    check(req, "done", done, 0);
  endtask

  // One complete machine cycle; kind 0..4, nWait wait states.
  task automatic runCycle(input logic [2:0] kind, input logic [15:0] addr,
                          input logic [7:0] wdata, input logic [7:0] rdata,
                          input int nWait);
    logic isRd, isWr, isIoK, isFetchK;
    logic [1:0] expStat;
    isFetchK = (kind == 3'd0);
    isRd  = (kind == 3'd0) || (kind == 3'd1) || (kind == 3'd3);
    isWr  = (kind == 3'd2) || (kind == 3'd4);
    isIoK = (kind == 3'd3) || (kind == 3'd4);
    expStat = isFetchK ? 2'b11 : (isRd ? 2'b10 : 2'b01);

    @(negedge clk);
    reqValid = 1'b1; reqKind = kind; reqAddr = addr; reqData = wdata;
    adIn = rdata; ready = 1'b1;
    @(negedge clk); // T1
    reqValid = 1'b0;
    check("R2", "T1 ale", ale, 1);
    check("R2", "T1 adDrive", adDrive, 1);
    check("R2", "T1 adOut", adOut, addr[7:0]);
    check("R2", "T1 addrHi", addrHi, addr[15:8]);
    check("R2", "T1 hiDrive", hiDrive, 1);
    check("R2", "T1 strobes", {rdN, wrN}, 2'b11);
    check("R6", "T1 status", status, expStat);
    check("R5", "T1 ioM", ioM, isIoK);
    @(negedge clk); // T2
    check("R2", "T2 ale", ale, 0);
    check("R3", "T2 rdN", rdN, !isRd);
    check("R4", "T2 wrN", wrN, !isWr);
    check("R4", "T2 adDrive", adDrive, isWr);
    if (isWr) check("R4", "T2 adOut", adOut, wdata);
    check("R6", "T2 status", status, expStat);
    check("R5", "T2 ioM", ioM, isIoK);
    check("R2", "T2 addrHi", addrHi, addr[15:8]);
    ready = (nWait == 0);
    for (int i = 0; i < nWait; i++) begin
      if (isRd) adIn = rdata ^ 8'hFF; // not yet the captured value
      @(negedge clk); // wait state
      // competing request during the cycle must be ignored
      reqValid = 1'b1; reqKind = 3'd2; reqAddr = 16'hDEAD;
      check("R8", "TW rdN", rdN, !isRd);
      check("R8", "TW wrN", wrN, !isWr);
      if (isWr) check("R4", "TW adOut", adOut, wdata);
      check("R6", "TW status", status, expStat);
      check("R5", "TW ioM", ioM, isIoK);
      ready = (i == nWait - 1);
      if (isRd && i == nWait - 1) adIn = rdata;
    end
    @(negedge clk); // T3
    reqValid = 1'b0;
    adIn = rdata ^ 8'h5A;
    check("R3", "T3 rdN", rdN, 1);
    check("R4", "T3 wrN", wrN, 1);
    check("R4", "T3 adDrive", adDrive, 0);
    check("R6", "T3 status", status, expStat);
    if (isFetchK) begin
      check("R7", "T3 done", done, 0);
      @(negedge clk); // T4
      check("R7", "T4 done", done, 1);
      check("R7", "T4 rdByte", rdByte, rdata);
      check("R7", "T4 strobes", {rdN, wrN}, 2'b11);
      check("R7", "T4 adDrive", adDrive, 0);
      check("R7", "T4 hiDrive", hiDrive, 1);
      check("R6", "T4 status", status, 2'b11);
      check("R5", "T4 ioM", ioM, 0);
    end else begin
      check(isRd ? "R3" : "R4", "T3 done", done, 1);
      if (isRd) check("R3", "T3 rdByte", rdByte, rdata);
      check("R5", "T3 ioM", ioM, isIoK);
    end
    @(negedge clk); // back to idle
    check("R9", "done single pulse", done, 0);
    checkIdle("R9");
    @(negedge clk);
    checkIdle("R9");
  endtask

  task automatic testReset();
    @(negedge clk);
    checkIdle("R1");
  endtask

  task automatic testBadKind();
    for (int k = 5; k < 8; k++) begin
      @(negedge clk);
      reqValid = 1'b1; reqKind = 3'(k); reqAddr = 16'hA5C3;
      @(negedge clk);
      reqValid = 1'b0;
      checkIdle("R10");
      @(negedge clk);
      checkIdle("R10");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    runCycle(3'd0, 16'h1234, 8'h00, 8'h3E, 0);   // fetch, no wait
    runCycle(3'd0, 16'h8001, 8'h00, 8'hC9, 2);   // fetch with waits
    runCycle(3'd1, 16'hBEEF, 8'h00, 8'h77, 0);   // memory read
    runCycle(3'd1, 16'h4411, 8'h00, 8'h96, 3);   // memory read with waits
    runCycle(3'd2, 16'h2233, 8'hA1, 8'h00, 0);   // memory write
    runCycle(3'd2, 16'h6655, 8'h3C, 8'h00, 1);   // memory write with wait
    runCycle(3'd3, 16'h0042, 8'h00, 8'h81, 1);   // I/O read
    runCycle(3'd4, 16'h00F0, 8'h5E, 8'h00, 0);   // I/O write
    runCycle(3'd4, 16'h0007, 8'hE7, 8'h00, 4);   // I/O write with waits
    testBadKind();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule